// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Selector

This block chooses which of two free-running, unrelated clocks reaches a single clock output, and it changes that choice without ever producing a shortened high or low phase. Each input has three controls. An enable and a select must both be high for the input to be a candidate. A bypass control removes the edge-wait protection for that one input. Input 0 wins when both inputs are candidates.

A handover is a two-sided handshake. The outgoing input's gate closes only after its own synchronizer has seen the deselection on its own idle-going edges. The incoming input's gate opens only after the outgoing side has let go, and again only on the incoming clock's own idle-going edges. Gates therefore change only while their clock sits at the idle level. Dropping an enable clears that input's synchronizer at once. With both selects held high, a switch made through the enables alone therefore does not wait on the clock being left.

The output's resting level while nothing is gated is a parameter. With a low idle level, the synchronizers run on falling edges. With a high idle level, they run on rising edges. An asynchronous reset clears every synchronizer and forces the output to the idle level.

Top module: `gfclk_mux`

## Requirements
- R1: An input is a candidate only while both its enable and its select are 1. Either one at 0 keeps that input off the output.
- R2: While no input is gated, clk_o holds the IDLE_HIGH level (0 by default) and shows no edges.
- R3: Without bypass, a deselected input keeps driving clk_o until its synchronizer has registered the change on two of its idle-going edges (falling edges for IDLE_HIGH=0). The new input is gated only after the old one has released, and only on its own idle-going edges. No high or low phase of clk_o is shorter than the shorter source half-period.
- R4: With bypass_k at 1, input k's gate follows its qualification combinationally. Release and take-over on that input happen without waiting for any of its clock edges.
- R5: Driving an enable to 0 removes that input from clk_o immediately, asynchronously, without waiting for an edge of that clock.
- R6: When both inputs are candidates, input 0 is passed. After reset is released, the first clock passed is the one whose enable and select are high.
- R7: rst_i at 1 asynchronously clears all synchronizer stages and forces clk_o to the idle level.
- R8: With IDLE_HIGH=1, the idle level is 1 and gating changes on rising edges. A deselected input therefore still drives clk_o through one full low phase before the output rests high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in0 | input | 1 | Clock source 0 |
| clk_in1 | input | 1 | Clock source 1 |
| rst_i | input | 1 | Asynchronous active-high reset |
| en0_i | input | 1 | Enable for source 0; a low level clears its synchronizer at once |
| sel0_i | input | 1 | Select for source 0 |
| bypass0_i | input | 1 | Skip edge synchronization on source 0 |
| en1_i | input | 1 | Enable for source 1; a low level clears its synchronizer at once |
| sel1_i | input | 1 | Select for source 1 |
| bypass1_i | input | 1 | Skip edge synchronization on source 1 |
| clk_o | output | 1 | Selected clock, or the idle level |

## Verification
The release of one input and the take-over by the other can fall together. The bench provokes this when input 0 is re-qualified while input 1 is running, because priority revokes input 1 in the same instant that input 0 asks for the output. The opposite direction produces the same overlap, and so do enable-only switches with both selects high.

Two clocks with incommensurate periods keep the edges of the two synchronizers drifting against each other. A monitor measures every clk_o phase against the shorter source half-period. After each change, the bench probes the output on the expected source's edges to confirm which clock is being passed.

// File: rtl/gfclk_pkg.sv
`timescale 1ns/1ps
package gfclk_pkg;

    localparam int unsigned NUM_IN     = 2;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] stage;
    } sync_state_t;

    typedef struct packed {
        logic [NUM_IN-1:0] want;
        logic [NUM_IN-1:0] busy;
        logic [NUM_IN-1:0] arm;
        logic [NUM_IN-1:0] gate;
    } qual_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_IN0  = 2'd1,
        SRC_IN1  = 2'd2
    } src_e;

endpackage

// File: rtl/gfclk_sync.sv
`timescale 1ns/1ps
module gfclk_sync
    import gfclk_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic arm_i,
    output logic busy_o,
    output logic gate_o
);

    logic ck_eff;
    logic clr;

    generate
        if (IDLE_HIGH) begin : g_rise
            assign ck_eff = ~clk_i;
        end else begin : g_fall
            assign ck_eff = clk_i;
        end
    endgenerate

    assign clr = rst_i | ~en_i;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.stage = {st_q.stage[SYNC_DEPTH-2:0], arm_i};
    end

    always_ff @(negedge ck_eff or posedge clr) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = |st_q.stage;
    assign gate_o = st_q.stage[SYNC_DEPTH-1];

    // R3
    gate_order_chk: assert property (@(negedge ck_eff) disable iff (clr)
        $rose(st_q.stage[SYNC_DEPTH-1]) |-> $past(st_q.stage[SYNC_DEPTH-2]));

    // R5
    en_clear_chk: assert property (@(posedge ck_eff) disable iff (rst_i)
        !en_i |-> (st_q.stage == '0));

endmodule

// File: rtl/gfclk_qualify.sv
`timescale 1ns/1ps
module gfclk_qualify
    import gfclk_pkg::*;
(
    input  logic [NUM_IN-1:0] en_i,
    input  logic [NUM_IN-1:0] sel_i,
    input  logic [NUM_IN-1:0] byp_i,
    input  logic [NUM_IN-1:0] busy_i,
    input  logic [NUM_IN-1:0] gate_sync_i,
    output logic [NUM_IN-1:0] arm_o,
    output logic [NUM_IN-1:0] gate_o
);

    qual_t q;

    always_comb begin
        logic              taken;
        logic [NUM_IN-1:0] self_m;
        q     = '0;
        taken = 1'b0;
        for (int k = 0; k < NUM_IN; k++) begin
            q.want[k] = en_i[k] & sel_i[k] & ~taken;
            taken     = taken | q.want[k];
        end
        for (int k = 0; k < NUM_IN; k++) begin
            q.busy[k] = byp_i[k] ? q.want[k] : busy_i[k];
        end
        for (int k = 0; k < NUM_IN; k++) begin
            self_m    = '0;
            self_m[k] = 1'b1;
            q.arm[k]  = q.want[k] & ~(|(q.busy & ~self_m));
            q.gate[k] = byp_i[k] ? q.arm[k] : gate_sync_i[k];
        end
    end

    assign arm_o  = q.arm;
    assign gate_o = q.gate;

endmodule

// File: rtl/gfclk_outsel.sv
`timescale 1ns/1ps
module gfclk_outsel
    import gfclk_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic [NUM_IN-1:0] clk_i,
    input  logic [NUM_IN-1:0] gate_i,
    output logic              clk_o
);

    src_e src;

    always_comb begin
        if (gate_i[0]) begin
            src = SRC_IN0;
        end else if (gate_i[1]) begin
            src = SRC_IN1;
        end else begin
            src = SRC_NONE;
        end
    end

    always_comb begin
        unique case (src)
            SRC_IN0: clk_o = clk_i[0];
            SRC_IN1: clk_o = clk_i[1];
            default: clk_o = IDLE_HIGH;
        endcase
    end

endmodule

// File: rtl/gfclk_mux.sv
`timescale 1ns/1ps
module gfclk_mux
    import gfclk_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic clk_in0,
    input  logic clk_in1,
    input  logic rst_i,
    input  logic en0_i,
    input  logic sel0_i,
    input  logic bypass0_i,
    input  logic en1_i,
    input  logic sel1_i,
    input  logic bypass1_i,
    output logic clk_o
);

    logic [NUM_IN-1:0] clk_v, en_v, sel_v, byp_v;
    logic [NUM_IN-1:0] arm_v, busy_v, gsync_v, gate_v;

    assign clk_v = {clk_in1, clk_in0};
    assign en_v  = {en1_i, en0_i};
    assign sel_v = {sel1_i, sel0_i};
    assign byp_v = {bypass1_i, bypass0_i};

    generate
        for (genvar k = 0; k < NUM_IN; k++) begin : g_sync
            gfclk_sync #(.IDLE_HIGH(IDLE_HIGH)) u_sync (
                .clk_i  (clk_v[k]),
                .rst_i  (rst_i),
                .en_i   (en_v[k]),
                .arm_i  (arm_v[k]),
                .busy_o (busy_v[k]),
                .gate_o (gsync_v[k])
            );
        end
    endgenerate

    gfclk_qualify u_qual (
        .en_i        (en_v),
        .sel_i       (sel_v),
        .byp_i       (byp_v),
        .busy_i      (busy_v),
        .gate_sync_i (gsync_v),
        .arm_o       (arm_v),
        .gate_o      (gate_v)
    );

    gfclk_outsel #(.IDLE_HIGH(IDLE_HIGH)) u_out (
        .clk_i  (clk_v),
        .gate_i (gate_v),
        .clk_o  (clk_o)
    );

    // R2
    idle_level_chk: assert property (@(posedge clk_in0) disable iff (rst_i)
        (gate_v == '0) |-> (clk_o == IDLE_HIGH));

    // R6
    prio_chk: assert property (@(posedge clk_in1) disable iff (rst_i)
        (en0_i && sel0_i) |-> !arm_v[1]);

    // R3
    gate_excl_chk: assert property (@(negedge clk_in0)
        disable iff (rst_i || bypass0_i || bypass1_i)
        !(gate_v[0] && gate_v[1]));

endmodule

// File: tb/gfclk_mux_tb_top.sv
`timescale 1ns/1ps
module gfclk_mux_tb_top;

    logic clk0 = 1'b0, clk1 = 1'b0, rst = 1'b1;
    logic en0 = 1'b0, sel0 = 1'b0, en1 = 1'b0, sel1 = 1'b0;
    logic byp0 = 1'b0, byp1 = 1'b0;
    logic clk_o, clk_h;

    int checks = 0, bad = 0, ph_bad = 0, edges_o = 0, edges_h = 0;
    bit mon_on = 1'b0, done = 1'b0;
    realtime last_o = 0.0;

    always #2.5 clk0 = ~clk0;
    initial begin
        #1.3;
        forever #3.7 clk1 = ~clk1;
    end

    gfclk_mux #(.IDLE_HIGH(1'b0)) dut_i (
        .clk_in0(clk0), .clk_in1(clk1), .rst_i(rst),
        .en0_i(en0), .sel0_i(sel0), .bypass0_i(byp0),
        .en1_i(en1), .sel1_i(sel1), .bypass1_i(byp1), .clk_o(clk_o));

    gfclk_mux #(.IDLE_HIGH(1'b1)) dut_h (
        .clk_in0(clk0), .clk_in1(clk1), .rst_i(rst),
        .en0_i(en0), .sel0_i(sel0), .bypass0_i(byp0),
        .en1_i(en1), .sel1_i(sel1), .bypass1_i(byp1), .clk_o(clk_h));

    always @(clk_o) begin
        edges_o++;
        if (mon_on) begin
            if ($realtime - last_o < 2.49) ph_bad++;
            last_o = $realtime;
        end
    end

    always @(clk_h) edges_h++;

    // {en0, sel0, en1, sel1, expected source: 0 idle, 1 clk0, 2 clk1}
    localparam logic [5:0] VEC [11] = '{
        6'b0000_00, 6'b1100_01, 6'b0011_10, 6'b1111_01, 6'b1011_10,
        6'b1110_01, 6'b0111_10, 6'b1111_01, 6'b0101_00, 6'b0011_10,
        6'b0010_00
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [3:0] v);
        {en0, sel0, en1, sel1} = v;
    endtask

    task automatic probe(input int src, output bit ok_i, output bit ok_h);
        int e0, eh;
        logic a, b, ah, bh;
        ok_i = 1'b1;
        ok_h = 1'b1;
        if (src == 0) begin
            e0 = edges_o;
            eh = edges_h;
            #30;
            ok_i = (edges_o == e0) && (clk_o === 1'b0);
            ok_h = (edges_h == eh) && (clk_h === 1'b1);
        end else begin
            for (int n = 0; n < 2; n++) begin
                if (src == 1) @(posedge clk0); else @(posedge clk1);
                #0.6;
                a = clk_o; ah = clk_h;
                if (src == 1) @(negedge clk0); else @(negedge clk1);
                #0.6;
                b = clk_o; bh = clk_h;
                ok_i = ok_i && (a === 1'b1) && (b === 1'b0);
                ok_h = ok_h && (ah === 1'b1) && (bh === 1'b0);
            end
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        #50000;
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog R1..R8 actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        bit oki, okh;
        int e0;
        // R7 / R2: reset holds idle even with input 0 qualified
        set_ctl(4'b1100);
        #1;
        e0 = edges_o;
        #30;
        chk((edges_o == e0) && (clk_o === 1'b0), "R7", "idle-low during reset",
            int'(clk_o), 0);
        chk(clk_h === 1'b1, "R2", "idle-high level during reset", int'(clk_h), 1);

        // R6: first clock passed is the qualified one
        @(negedge clk0); #0.2; rst = 1'b0;
        #40;
        probe(1, oki, okh);
        chk(oki, "R6", "first clock after reset is clk0", int'(oki), 1);

        // table walk with phase monitor
        last_o = -100.0;
        mon_on = 1'b1;
        for (int i = 0; i < 11; i++) begin
            @(negedge clk0); #0.2;
            set_ctl(VEC[i][5:2]);
            #60;
            probe(int'(VEC[i][1:0]), oki, okh);
            // R1 R2 R3 R6: source selection per vector
            chk(oki, "R1/R6", $sformatf("vector %0d source", i), int'(oki), 1);
            // R8: idle-high variant follows same source
            chk(okh, "R8", $sformatf("vector %0d idle-high source", i), int'(okh), 1);
        end
        chk(ph_bad == 0, "R3", "short output phases", ph_bad, 0);
        mon_on = 1'b0;

        // R3: select drop waits two falling edges of the outgoing clock
        @(negedge clk0); #0.2; set_ctl(4'b1100); #40;
        @(posedge clk0); #0.6; sel0 = 1'b0;
        @(posedge clk0); #0.6;
        chk(clk_o === 1'b1, "R3", "still passing after one falling edge", int'(clk_o), 1);
        @(posedge clk0); #0.6;
        chk(clk_o === 1'b0, "R3", "released after two falling edges", int'(clk_o), 0);

        // R8: idle-high variant releases on rising edges
        @(negedge clk0); #0.2; set_ctl(4'b1100); #40;
        @(negedge clk0); #0.6; sel0 = 1'b0;
        @(negedge clk0); #0.6;
        chk(clk_h === 1'b0, "R8", "still passing after one rising edge", int'(clk_h), 0);
        @(negedge clk0); #0.6;
        chk(clk_h === 1'b1, "R8", "rests high after two rising edges", int'(clk_h), 1);

        // R5: enable drop cuts immediately
        @(negedge clk0); #0.2; set_ctl(4'b1100); #40;
        @(posedge clk0); #0.6; en0 = 1'b0;
        #0.2;
        chk(clk_o === 1'b0, "R5", "enable drop while clk0 high", int'(clk_o), 0);

        // R4: bypass on outgoing input
        @(negedge clk0); #0.2; byp0 = 1'b1; set_ctl(4'b1100); #40;
        @(posedge clk0); #0.6; sel0 = 1'b0;
        #0.2;
        chk(clk_o === 1'b0, "R4", "bypassed release is immediate", int'(clk_o), 0);
        byp0 = 1'b0;
        @(negedge clk0); #0.2; set_ctl(4'b0000); #40;

        // R4: bypass on incoming input
        byp1 = 1'b1;
        @(posedge clk1); #0.6; en1 = 1'b1; sel1 = 1'b1;
        #0.2;
        chk(clk_o === 1'b1, "R4", "bypassed take-over is immediate", int'(clk_o), 1);
        byp1 = 1'b0;
        #40;

        // R7: reset mid-run forces idle at once
        @(posedge clk1); #0.6; rst = 1'b1;
        #0.2;
        chk(clk_o === 1'b0, "R7", "reset while clk1 high", int'(clk_o), 0);
        chk(clk_h === 1'b1, "R7", "reset idle-high variant", int'(clk_h), 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule